// File: doc/BRIEF.md
# Register Programming Command Sequencer

The sequencer walks a table of 32-bit command words and turns it into traffic on a simple request/acknowledge register bus. After a start pulse it reads the table one word per fetch from a memory with one cycle of read latency, beginning at a given word offset. It takes the opcode from the top four bits of each header word and reads the operand words that follow. Then it performs the command: a plain register write, a write into an indexed register space, a masked read-modify-write, or a poll that re-reads a register until its masked value equals an expected value.

An end command stops the walk with a done flag. Three faults stop it with an error flag and a two-bit code: an opcode the sequencer does not know, a walk that needs more words than the table size given at start, and a poll that runs past its cycle limit. The flags stay set until the next accepted start. A word counter shows how many table words the run has consumed.

Top module: `regseq_engine`

## Requirements
- R1: A start pulse while idle loads the fetch pointer with the start offset, clears done, err, err_code and the word counter, and raises busy on the next cycle; the first table read uses the start offset.
- R2: Opcode 0 in header bits [31:28] is a two-word direct write: one bus write with bus_ind=0, bus_space=0, address = header bits [27:0], data = the second word.
- R3: Opcode 8 is a two-word indexed write: one bus write with bus_ind=1, bus_space = header bits [27:20], address = header bits [19:0] zero-extended, data = the second word.
- R4: Opcode 3 is a three-word read-modify-write (header, data, mask): one read of header bits [27:0], then one write of (old & ~mask) | (data & mask) to the same address.
- R5: Opcode 2 is a three-word poll (header, mask, expected): it repeats reads of header bits [27:0] until (read & mask) == expected, then moves to the next command.
- R6: A poll read that does not match, completing once at least poll_limit cycles have passed since the poll's last operand was loaded, stops the run with err=1 and err_code=3 and issues no further bus access.
- R7: Opcode 0xF stops the run with done=1, err=0, busy=0; the end word is counted.
- R8: Any other opcode stops the run with err=1, err_code=1 and causes no bus access.
- R9: When a word must be fetched and the word counter already equals table_words, the run stops with err=1, err_code=2, also in the middle of a command.
- R10: Once bus_req rises, it and bus_we, bus_ind, bus_space, bus_addr and bus_wdata hold steady until the cycle in which bus_ack is seen.
- R11: done, err and err_code keep their values until the next accepted start; a start pulse while busy is ignored.
- R12: words_done counts every table word fetched since the last accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| start_ofs | input | AW | Word offset of the first command |
| table_words | input | AW+1 | Table size in words |
| poll_limit | input | TW | Poll timeout in cycles |
| tbl_rd | output | 1 | Table read strobe |
| tbl_addr | output | AW | Table word address |
| tbl_rdata | input | DW | Table word, valid the cycle after tbl_rd |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_ind | output | 1 | Access targets an indexed register space |
| bus_space | output | 8 | Index space selector |
| bus_addr | output | 28 | Register offset |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Bus acknowledge, one cycle per request |
| bus_rdata | input | DW | Read data, valid with bus_ack |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run ended at an end command |
| err | output | 1 | Run ended on a fault |
| err_code | output | 2 | 1 bad opcode, 2 table overrun, 3 poll timeout |
| words_done | output | AW+1 | Words consumed in this run |

## Verification
The assertions assume that table_words and poll_limit do not change while busy and that bus_ack comes only in answer to a pending request. They also assume table data arrives one cycle after each read strobe. The bench sets all run inputs before the start pulse and changes only start_ofs during a run, to test that a start while busy is ignored. Its bus slave raises a single-cycle acknowledge one cycle after each request. Its table memory answers reads with a registered one-cycle read.

// File: rtl/regseq_pkg.sv
package regseq_pkg;
   localparam int HDR_OFS_W = 28;
   localparam int IDX_OFS_W = 20;
   localparam int SPACE_W   = 8;

   typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_LOAD, ST_ISSUE, ST_WAIT} st_e;
   typedef enum logic [2:0] {K_WR, K_IWR, K_RMW, K_POLL, K_END, K_BAD} kind_e;
   typedef enum logic [1:0] {E_NONE = 2'd0, E_BADOP = 2'd1, E_OVERRUN = 2'd2, E_TIMEOUT = 2'd3} err_e;

   // Words per command, header included
   function automatic logic [1:0] op_len(kind_e k);
      case (k)
         K_WR, K_IWR:   op_len = 2'd2;
         K_RMW, K_POLL: op_len = 2'd3;
         default:       op_len = 2'd1;
      endcase
   endfunction
endpackage

// File: rtl/regseq_decode.sv
module regseq_decode
   import regseq_pkg::*;
(
   input  logic [3:0] op,
   output kind_e      kind
);
   always_comb begin
      case (op)
         4'h0:    kind = K_WR;
         4'h2:    kind = K_POLL;
         4'h3:    kind = K_RMW;
         4'h8:    kind = K_IWR;
         4'hF:    kind = K_END;
         default: kind = K_BAD;
      endcase
   end
endmodule

// File: rtl/regseq_polltimer.sv
module regseq_polltimer #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [TW-1:0] limit,
   output logic          expired
);
   logic [TW-1:0] tcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             tcnt <= '0;
      else if (clr)           tcnt <= '0;
      else if (tcnt != '1)    tcnt <= tcnt + 1'b1;
   end

   assign expired = (tcnt >= limit);
endmodule

// File: rtl/regseq_busport.sv
module regseq_busport
   import regseq_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go,
   input  logic                 go_we,
   input  logic                 go_ind,
   input  logic [SPACE_W-1:0]   go_space,
   input  logic [HDR_OFS_W-1:0] go_addr,
   input  logic [DW-1:0]        go_wdata,
   input  logic                 bus_ack,
   output logic                 bus_req,
   output logic                 bus_we,
   output logic                 bus_ind,
   output logic [SPACE_W-1:0]   bus_space,
   output logic [HDR_OFS_W-1:0] bus_addr,
   output logic [DW-1:0]        bus_wdata,
   output logic                 fin
);
   assign fin = bus_req & bus_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_req   <= 1'b0;
         bus_we    <= 1'b0;
         bus_ind   <= 1'b0;
         bus_space <= '0;
         bus_addr  <= '0;
         bus_wdata <= '0;
      end else if (go) begin
         bus_req   <= 1'b1;
         bus_we    <= go_we;
         bus_ind   <= go_ind;
         bus_space <= go_space;
         bus_addr  <= go_addr;
         bus_wdata <= go_wdata;
      end else if (fin) begin
         bus_req   <= 1'b0;
      end
   end
endmodule

// File: rtl/regseq_engine.sv
module regseq_engine
   import regseq_pkg::*;
#(
   parameter int AW = 8,
   parameter int TW = 16,
   parameter int DW = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [AW-1:0]        start_ofs,
   input  logic [AW:0]          table_words,
   input  logic [TW-1:0]        poll_limit,
   output logic                 tbl_rd,
   output logic [AW-1:0]        tbl_addr,
   input  logic [DW-1:0]        tbl_rdata,
   output logic                 bus_req,
   output logic                 bus_we,
   output logic                 bus_ind,
   output logic [SPACE_W-1:0]   bus_space,
   output logic [HDR_OFS_W-1:0] bus_addr,
   output logic [DW-1:0]        bus_wdata,
   input  logic                 bus_ack,
   input  logic [DW-1:0]        bus_rdata,
   output logic                 busy,
   output logic                 done,
   output logic                 err,
   output logic [1:0]           err_code,
   output logic [AW:0]          words_done
);
   localparam int NSLOT = 3;

   if (DW != 32) begin : g_bad_dw
      $error("regseq_engine: command words are 32 bits wide");
   end
   if (AW < 2) begin : g_bad_aw
      $error("regseq_engine: AW must be at least 2");
   end
   if (TW < 1) begin : g_bad_tw
      $error("regseq_engine: TW must be at least 1");
   end

   st_e           st;
   err_e          code_q;
   logic [AW-1:0] ptr;
   logic [AW:0]   cnt;
   logic [1:0]    idx;
   logic          phase;
   logic [DW-1:0] old_q;
   logic [DW-1:0] slot [NSLOT];

   // Operand capture: one register per word position of a command
   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    q <= '0;
         else if (st == ST_LOAD && idx == 2'(g))        q <= tbl_rdata;
      end
      assign slot[g] = q;
   end

   kind_e load_kind, exe_kind;
   regseq_decode u_dec_load (.op(tbl_rdata[31:28]), .kind(load_kind));
   regseq_decode u_dec_exe  (.op(slot[0][31:28]),   .kind(exe_kind));

   logic [1:0] need;
   assign need = op_len(exe_kind);

   logic expired;
   regseq_polltimer #(.TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(st == ST_LOAD),
      .limit(poll_limit), .expired(expired)
   );

   // Execute-phase request fields
   logic                 go, go_we, go_ind, fin, match;
   logic [SPACE_W-1:0]   go_space;
   logic [HDR_OFS_W-1:0] go_addr;
   logic [DW-1:0]        go_wdata;

   assign go      = (st == ST_ISSUE);
   assign go_ind  = (exe_kind == K_IWR);
   assign go_we   = (exe_kind == K_WR) || (exe_kind == K_IWR) || (exe_kind == K_RMW && phase);
   assign go_space = go_ind ? slot[0][27:20] : '0;
   assign go_addr  = go_ind ? {{(HDR_OFS_W-IDX_OFS_W){1'b0}}, slot[0][IDX_OFS_W-1:0]}
                            : slot[0][HDR_OFS_W-1:0];
   assign go_wdata = (exe_kind == K_RMW) ? ((old_q & ~slot[2]) | (slot[1] & slot[2])) : slot[1];
   assign match    = ((bus_rdata & slot[1]) == slot[2]);

   regseq_busport #(.DW(DW)) u_bus (
      .clk(clk), .rst_n(rst_n), .go(go), .go_we(go_we), .go_ind(go_ind),
      .go_space(go_space), .go_addr(go_addr), .go_wdata(go_wdata),
      .bus_ack(bus_ack), .bus_req(bus_req), .bus_we(bus_we), .bus_ind(bus_ind),
      .bus_space(bus_space), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .fin(fin)
   );

   assign tbl_rd     = (st == ST_FETCH) && (cnt != table_words);
   assign tbl_addr   = ptr;
   assign busy       = (st != ST_IDLE);
   assign err_code   = code_q;
   assign words_done = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; code_q <= E_NONE; ptr <= '0; cnt <= '0;
         idx <= '0; phase <= 1'b0; old_q <= '0; done <= 1'b0; err <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               ptr <= start_ofs; cnt <= '0; idx <= '0;
               done <= 1'b0; err <= 1'b0; code_q <= E_NONE;
               st <= ST_FETCH;
            end
            ST_FETCH: if (cnt == table_words) begin
               err <= 1'b1; code_q <= E_OVERRUN; st <= ST_IDLE;
            end else begin
               st <= ST_LOAD;
            end
            ST_LOAD: begin
               ptr <= ptr + 1'b1;
               cnt <= cnt + 1'b1;
               if (idx == 2'd0) begin
                  case (load_kind)
                     K_END:   begin done <= 1'b1; st <= ST_IDLE; end
                     K_BAD:   begin err <= 1'b1; code_q <= E_BADOP; st <= ST_IDLE; end
                     default: begin idx <= 2'd1; st <= ST_FETCH; end
                  endcase
               end else if (idx == need - 2'd1) begin
                  idx <= '0; phase <= 1'b0; st <= ST_ISSUE;
               end else begin
                  idx <= idx + 2'd1; st <= ST_FETCH;
               end
            end
            ST_ISSUE: st <= ST_WAIT;
            ST_WAIT: if (fin) begin
               case (exe_kind)
                  K_RMW: if (!phase) begin
                     old_q <= bus_rdata; phase <= 1'b1; st <= ST_ISSUE;
                  end else begin
                     st <= ST_FETCH;
                  end
                  K_POLL: if (match)        st <= ST_FETCH;
                          else if (expired) begin
                             err <= 1'b1; code_q <= E_TIMEOUT; st <= ST_IDLE;
                          end else          st <= ST_ISSUE;
                  default: st <= ST_FETCH;
               endcase
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/regseq_engine_chk.sv
module regseq_engine_chk #(
   parameter int AW = 8,
   parameter int TW = 16,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [AW:0]   table_words,
   input logic          tbl_rd,
   input logic          bus_req,
   input logic          bus_we,
   input logic          bus_ind,
   input logic [7:0]    bus_space,
   input logic [27:0]   bus_addr,
   input logic [DW-1:0] bus_wdata,
   input logic          bus_ack,
   input logic          busy,
   input logic          done,
   input logic          err,
   input logic [1:0]    err_code,
   input logic [AW:0]   words_done
);
   assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy && !done && !err && words_done == '0);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_req && !tbl_rd);

   assert_ind_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_ind |-> bus_addr[27:20] == 8'd0);

   assert_code_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_code != 2'd0) == err);

   assert_no_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> words_done <= table_words);

   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_ind)
                              && $stable(bus_space) && $stable(bus_addr) && $stable(bus_wdata));

   assert_flag_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

   assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) && !start |=> $stable(done) && $stable(err) && $stable(err_code));
endmodule

bind regseq_engine regseq_engine_chk #(.AW(AW), .TW(TW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .table_words(table_words), .tbl_rd(tbl_rd),
   .bus_req(bus_req), .bus_we(bus_we), .bus_ind(bus_ind), .bus_space(bus_space),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .busy(busy),
   .done(done), .err(err), .err_code(err_code), .words_done(words_done)
);

// File: tb/sim_regseq_engine.sv
module sim_regseq_engine;
   localparam int AW = 8;
   localparam int TW = 16;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] start_ofs = '0;
   logic [AW:0]   table_words = '0;
   logic [TW-1:0] poll_limit = '0;
   logic          tbl_rd;
   logic [AW-1:0] tbl_addr;
   logic [DW-1:0] tbl_rdata = '0;
   logic          bus_req, bus_we, bus_ind;
   logic [7:0]    bus_space;
   logic [27:0]   bus_addr;
   logic [DW-1:0] bus_wdata;
   logic          bus_ack = 1'b0;
   logic [DW-1:0] bus_rdata = '0;
   logic          busy, done, err;
   logic [1:0]    err_code;
   logic [AW:0]   words_done;

   always #10 clk = ~clk;  // 50 MHz

   regseq_engine #(.AW(AW), .TW(TW), .DW(DW)) u0 (.*);

   int total = 0;
   int bad = 0;

   task automatic chk(string tag, logic [79:0] act, logic [79:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Table memory with one-cycle registered read
   logic [DW-1:0] mem [0:255];
   int wp;
   always @(posedge clk) if (tbl_rd) tbl_rdata <= mem[tbl_addr];
   task automatic put(logic [31:0] w); mem[wp] = w; wp++; endtask

   // Bus slave: reads of offset 7 return a count of earlier reads there
   logic [DW-1:0] regs [0:15];
   logic [DW-1:0] rd7;
   always @(posedge clk) begin
      if (!rst_n) begin
         bus_ack <= 1'b0; rd7 <= '0;
      end else begin
         bus_ack <= bus_req && !bus_ack;
         if (bus_req && !bus_ack && !bus_we) begin
            if (bus_addr == 28'd7) begin bus_rdata <= rd7; rd7 <= rd7 + 1; end
            else bus_rdata <= regs[bus_addr[3:0]];
         end
         if (bus_req && bus_ack && bus_we && !bus_ind) regs[bus_addr[3:0]] <= bus_wdata;
      end
   end

   // Scoreboard of expected bus writes {ind, space, addr, data}
   logic [68:0] expq [$];
   string       tagq [$];
   task automatic add_wr(string tag, logic ind, logic [7:0] sp, logic [27:0] a, logic [31:0] d);
      expq.push_back({ind, sp, a, d});
      tagq.push_back(tag);
   endtask

   logic        req_prev = 1'b0;
   logic [60:0] held;
   always @(negedge clk) begin
      if (rst_n) begin
         if (bus_req && !req_prev) held = {bus_we, bus_addr, bus_wdata};
         if (bus_req && bus_ack) begin
            chk("R10 request fields held until ack", {bus_we, bus_addr, bus_wdata}, held);
            if (bus_we) begin
               if (expq.size() == 0) chk("R2 unexpected bus write", {bus_ind, bus_space, bus_addr, bus_wdata}, '0);
               else chk(tagq.pop_front(), {bus_ind, bus_space, bus_addr, bus_wdata}, expq.pop_front());
            end
         end
      end
      req_prev = bus_req;
   end

   task automatic pulse_start(logic [AW-1:0] ofs);
      @(negedge clk);
      start_ofs = ofs; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int n = 0; n < 20000 && busy; n++) @(negedge clk);
   endtask

   task automatic run(logic [AW-1:0] ofs, logic [AW:0] words, logic [TW-1:0] lim);
      table_words = words; poll_limit = lim;
      pulse_start(ofs);
      chk("R1 busy/flags/counter after start", {busy, done, err, err_code, words_done}, {1'b1, 1'b0, 1'b0, 2'd0, 9'd0});
      wait_idle();
      @(negedge clk);
      chk("R2 all expected writes seen", 80'(expq.size()), 80'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'h5000_0000;
      for (int i = 0; i < 16; i++) regs[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset state", {busy, done, err, err_code, words_done, bus_req, tbl_rd},
          {1'b0, 1'b0, 1'b0, 2'd0, 9'd0, 1'b0, 1'b0});

      // Program A at offset 10: write, indexed write, RMW, poll, write, end
      wp = 10;
      put({4'h0, 28'h3}); put(32'h0000_AABB);
      put({4'h8, 8'h5A, 20'h12345}); put(32'h0000_0011);
      put({4'h3, 28'h3}); put(32'h0000_0F0F); put(32'h0000_00FF);
      put({4'h2, 28'h7}); put(32'h0000_00FF); put(32'h0000_0003);
      put({4'h0, 28'h9}); put(32'h0000_0099);
      put({4'hF, 28'h0});
      add_wr("R2 direct write", 1'b0, 8'h00, 28'h3, 32'h0000_AABB);
      add_wr("R3 indexed write", 1'b1, 8'h5A, 28'h12345, 32'h0000_0011);
      add_wr("R4 read-modify-write merge", 1'b0, 8'h00, 28'h3, 32'h0000_AA0F);
      add_wr("R5 write after poll matched", 1'b0, 8'h00, 28'h9, 32'h0000_0099);
      run(8'd10, 9'd20, 16'd1000);
      chk("R7 end: done set", {busy, done, err, err_code}, {1'b0, 1'b1, 1'b0, 2'd0});
      chk("R12 words counted incl end", 80'(words_done), 80'd13);
      chk("R5 poll re-read until match", 80'(rd7), 80'd4);
      repeat (10) @(negedge clk);
      chk("R11 done sticky", {done, err, err_code}, {1'b1, 1'b0, 2'd0});

      // Unknown opcode after one write
      wp = 30;
      put({4'h0, 28'h4}); put(32'h1234_5678);
      put({4'h5, 28'h4}); put({4'h0, 28'h4}); put(32'h0);
      add_wr("R8 write before bad opcode", 1'b0, 8'h00, 28'h4, 32'h1234_5678);
      run(8'd30, 9'd10, 16'd1000);
      chk("R8 bad opcode error", {done, err, err_code}, {1'b0, 1'b1, 2'd1});
      chk("R8 words at bad opcode", 80'(words_done), 80'd3);

      // Overrun in the middle of a read-modify-write
      wp = 40;
      put({4'h0, 28'h5}); put(32'h0000_0055);
      put({4'h3, 28'h5}); put(32'hFFFF_FFFF); put(32'hFFFF_FFFF); put({4'hF, 28'h0});
      add_wr("R9 write before overrun", 1'b0, 8'h00, 28'h5, 32'h0000_0055);
      run(8'd40, 9'd3, 16'd1000);
      chk("R9 overrun error", {done, err, err_code}, {1'b0, 1'b1, 2'd2});
      chk("R9 words at overrun", 80'(words_done), 80'd3);
      chk("R9 register untouched by cut RMW", 80'(regs[5]), 80'h55);

      // Poll timeout, later write must not appear
      wp = 50;
      put({4'h2, 28'h7}); put(32'hFFFF_FFFF); put(32'hDEAD_0000);
      put({4'h0, 28'h6}); put(32'h6666_6666); put({4'hF, 28'h0});
      run(8'd50, 9'd10, 16'd20);
      chk("R6 poll timeout error", {done, err, err_code}, {1'b0, 1'b1, 2'd3});
      chk("R6 words at timeout", 80'(words_done), 80'd3);
      chk("R6 no write after timeout", 80'(regs[6]), 80'h0);
      repeat (10) @(negedge clk);
      chk("R11 err sticky", {done, err, err_code}, {1'b0, 1'b1, 2'd3});

      // Start while busy is ignored: table at 0 holds only an end command
      mem[0] = {4'hF, 28'h0};
      poll_limit = 16'd200;
      pulse_start(8'd50);
      repeat (30) @(negedge clk);
      pulse_start(8'd0);
      wait_idle();
      @(negedge clk);
      chk("R11 start while busy ignored", {done, err, err_code, words_done}, {1'b0, 1'b1, 2'd3, 9'd3});

      // End command alone
      run(8'd0, 9'd5, 16'd10);
      chk("R7 lone end command", {done, err, err_code, words_done}, {1'b1, 1'b0, 2'd0, 9'd1});

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule